// File: doc/BRIEF.md
# HDLC Frame Receiver with Masked Address Filter

This block receives one bit-serial HDLC channel. Each bit arrives on `bit_in` and is taken only in a cycle where `bit_en` is high. The 0x7E flag marks the frame boundaries. The receiver removes the zero that follows five consecutive ones and assembles bytes least significant bit first. A run of seven ones stops the receiver. In transparent mode the receiver does two more things. It compares the first byte of each frame with an address value, using a per-bit mask. It also checks the CRC-16-CCITT frame check sequence, which is preset to all ones; a good frame leaves the residue 0xF0B8.

Accepted bytes go into a 32-entry receive FIFO, including the two check bytes. A host pops the FIFO through a show-ahead byte port. The host also sees three sticky status bits and three one-cycle interrupt pulses. It has two command inputs: `cmd_rrst` resets the receiver and `cmd_rack` acknowledges a frame.

A five-state machine runs the block:
- **HUNT** waits for a flag.
- **OPEN** has seen a flag and waits for the first byte.
- **BODY** stores an accepted frame.
- **SKIP** drops a frame whose address did not match.
- **HALT** holds after an abort.

Transitions:
- HUNT→OPEN on a flag.
- OPEN→BODY when the first byte matches. OPEN→SKIP when it does not.
- OPEN→OPEN on a repeated flag.
- OPEN→HUNT and SKIP→HUNT on seven ones.
- BODY→OPEN on the closing flag (end of message).
- BODY→HALT on seven ones.
- SKIP→OPEN on a flag.
- Any state→HUNT on `cmd_rrst`.

Top module: `hdlc_rx_filt`

## Requirements
- R1: Bytes found between two flags go into the FIFO in arrival order. Each byte is assembled least significant bit first, and a 0 that follows five 1s is deleted. The two check bytes are stored after the payload, low byte first.
- R2: Seven consecutive 1s after at least one byte of an accepted frame set `st_abort` and give no `irq_eom`. The receiver then ignores all input until `cmd_rrst`, and `st_abort` stays 1 until then.
- R3: After `rst_n` or `cmd_rrst`:
  - the FIFO is empty (`fifo_empty`=1);
  - `st_abort`, `st_ovf` and `st_crc_err` are 0;
  - the receiver hunts for a new flag.
- R4: A byte written into a full FIFO (32 entries, no read in that cycle) overwrites the oldest entry. It also sets `st_ovf` and pulses `irq_ovf` for one cycle. `st_ovf` stays 1 until `cmd_rrst`.
- R5: At the closing flag of an accepted frame, `st_crc_err` takes a value from the mode:
  - with `transp_en`=1: 1 if the CRC residue is not 0xF0B8 or the frame did not end on a byte boundary, otherwise 0;
  - with `transp_en`=0: 0.
- R6: `st_crc_err` keeps its value from the end of message until `cmd_rack` clears it, or until the next end of message or `cmd_rrst`.
- R7: With `transp_en`=1, a frame is accepted only if, for every bit i where `addr_mask[i]`=0, bit i of the first byte equals `addr_val[i]`. Bits where `addr_mask[i]`=1 are not compared.
- R8: A frame that fails R7 writes nothing to the FIFO and raises no `irq_eom`. With `transp_en`=0, every frame is accepted.
- R9: `irq_ready` pulses for one cycle when a write raises the FIFO fill to 16 entries.
- R10: `irq_eom` pulses for one cycle at the closing flag of an accepted frame. At the same time `eom_count` takes the number of bytes the frame wrote, check bytes included, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| transp_en | input | 1 | Transparent mode: turns on the address filter and the CRC check |
| addr_val | input | 8 | Address compared with the first byte |
| addr_mask | input | 8 | 1 = bit not compared |
| cmd_rrst | input | 1 | Receiver reset command (one-cycle pulse) |
| cmd_rack | input | 1 | Frame acknowledge; clears `st_crc_err` |
| rd_en | input | 1 | Pops one FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte (show-ahead) |
| fifo_empty | output | 1 | FIFO holds no bytes |
| st_abort | output | 1 | Sticky abort status |
| st_ovf | output | 1 | Sticky overflow status |
| st_crc_err | output | 1 | CRC result of the last frame |
| eom_count | output | 8 | Bytes written by the last accepted frame |
| irq_ready | output | 1 | Pulse: FIFO fill reached 16 |
| irq_eom | output | 1 | Pulse: end of an accepted frame |
| irq_ovf | output | 1 | Pulse: FIFO overwritten |

## Verification
The assertions take three things for granted:
- `cmd_rrst` and `cmd_rack` are single-cycle pulses.
- `transp_en` is not changed while a frame is on the line.
- `rd_en` is not raised while the FIFO is empty.

The bench drives the mode and the address inputs only in idle gaps between frames. It pulses each command for exactly one cycle at a falling edge, and it pops the FIFO only as many times as the bytes it expects are stored. Bits are sent with `bit_en` high for one cycle in every two, so each decision in the receiver is tied to exactly one strobed bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPEN,
        ST_BODY,
        ST_SKIP,
        ST_HALT
    } rx_state_e;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;

    // Reflected CRC-16-CCITT update over one byte, LSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_bit_deframer.sv
module hdlc_bit_deframer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       flag_ev,
    output logic       abort_ev,
    output logic       byte_vld,
    output logic [7:0] byte_val,
    output logic       aligned
);
    logic [2:0] ones;
    logic [2:0] bitcnt;
    logic [6:0] sh;
    logic       stuff, data_bit;

    always_comb begin
        flag_ev  = bit_en && !bit_in && (ones == 3'd6);
        abort_ev = bit_en &&  bit_in && (ones == 3'd6);
        stuff    = bit_en && !bit_in && (ones == 3'd5);
        data_bit = bit_en && !flag_ev && !abort_ev && !stuff && (ones != 3'd7);
        byte_vld = data_bit && (bitcnt == 3'd7);
        byte_val = {bit_in, sh};
        aligned  = (bitcnt == 3'd7);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones   <= '0;
            bitcnt <= '0;
            sh     <= '0;
        end else if (clr) begin
            ones   <= '0;
            bitcnt <= '0;
        end else if (bit_en) begin
            ones <= bit_in ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
            if (flag_ev) begin
                bitcnt <= '0;
            end else if (data_bit) begin
                bitcnt <= bitcnt + 3'd1;
                sh     <= {bit_in, sh[6:1]};
            end
        end
    end
endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16
    import hdlc_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic        good
);
    logic [15:0] crc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= CRC_PRESET;
        else if (clr) crc <= CRC_PRESET;
        else if (upd) crc <= crc16_step(crc, din);
    end

    assign good = (crc == CRC_RESIDUE);
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int THR   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       empty,
    output logic       ovf,
    output logic       thr_hit
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, rd_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign rd_ok   = rd && !empty;
    assign ovf     = wr && full && !rd_ok;
    assign thr_hit = wr && !full && !rd_ok && (cnt == CW'(THR - 1));
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (wr && !clr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) wp <= bump(wp);
            if (rd_ok || ovf) rp <= bump(rp);
            if (!ovf) cnt <= cnt + CW'(wr) - CW'(rd_ok);
        end
    end
endmodule

// File: rtl/hdlc_rx_filt.sv
module hdlc_rx_filt
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int READY_THR  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       transp_en,
    input  logic [7:0] addr_val,
    input  logic [7:0] addr_mask,
    input  logic       cmd_rrst,
    input  logic       cmd_rack,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       fifo_empty,
    output logic       st_abort,
    output logic       st_ovf,
    output logic       st_crc_err,
    output logic [7:0] eom_count,
    output logic       irq_ready,
    output logic       irq_eom,
    output logic       irq_ovf
);
    rx_state_e  state, nxt;
    logic       flag_ev, abort_ev, byte_vld, aligned;
    logic [7:0] byte_val;
    logic       addr_ok, fifo_wr, eom_ev, crc_good, ovf_ev, thr_ev;
    logic [7:0] frame_cnt;

    hdlc_bit_deframer u_dfr (
        .clk(clk), .rst_n(rst_n), .clr(cmd_rrst),
        .bit_en(bit_en), .bit_in(bit_in),
        .flag_ev(flag_ev), .abort_ev(abort_ev),
        .byte_vld(byte_vld), .byte_val(byte_val), .aligned(aligned)
    );

    hdlc_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(flag_ev || cmd_rrst),
        .upd(fifo_wr), .din(byte_val), .good(crc_good)
    );

    hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH), .THR(READY_THR)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(cmd_rrst),
        .wr(fifo_wr), .wdata(byte_val), .rd(rd_en),
        .rdata(rd_data), .empty(fifo_empty), .ovf(ovf_ev), .thr_hit(thr_ev)
    );

    assign addr_ok = !transp_en || (((byte_val ^ addr_val) & ~addr_mask) == 8'h00);
    assign fifo_wr = !cmd_rrst && byte_vld &&
                     ((state == ST_BODY) || ((state == ST_OPEN) && addr_ok));
    assign eom_ev  = !cmd_rrst && flag_ev && (state == ST_BODY);

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: if (flag_ev) nxt = ST_OPEN;
            ST_OPEN: begin
                if (abort_ev)      nxt = ST_HUNT;
                else if (byte_vld) nxt = addr_ok ? ST_BODY : ST_SKIP;
            end
            ST_BODY: begin
                if (abort_ev)      nxt = ST_HALT;
                else if (flag_ev)  nxt = ST_OPEN;
            end
            ST_SKIP: begin
                if (abort_ev)      nxt = ST_HUNT;
                else if (flag_ev)  nxt = ST_OPEN;
            end
            ST_HALT: nxt = ST_HALT;
            default: nxt = ST_HUNT;
        endcase
        if (cmd_rrst) nxt = ST_HUNT;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // Outputs: status, pulses, counts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_abort   <= 1'b0;
            st_ovf     <= 1'b0;
            st_crc_err <= 1'b0;
            eom_count  <= '0;
            frame_cnt  <= '0;
            irq_ready  <= 1'b0;
            irq_eom    <= 1'b0;
            irq_ovf    <= 1'b0;
        end else if (cmd_rrst) begin
            st_abort   <= 1'b0;
            st_ovf     <= 1'b0;
            st_crc_err <= 1'b0;
            frame_cnt  <= '0;
            irq_ready  <= 1'b0;
            irq_eom    <= 1'b0;
            irq_ovf    <= 1'b0;
        end else begin
            irq_ready <= thr_ev;
            irq_ovf   <= ovf_ev;
            irq_eom   <= eom_ev;
            if (ovf_ev) st_ovf <= 1'b1;
            if ((state == ST_BODY) && abort_ev) st_abort <= 1'b1;
            if (flag_ev)      frame_cnt <= '0;
            else if (fifo_wr) frame_cnt <= frame_cnt + 8'd1;
            if (eom_ev) begin
                eom_count  <= frame_cnt;
                st_crc_err <= transp_en && (!crc_good || !aligned);
            end else if (cmd_rack) begin
                st_crc_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_filt_chk.sv
module hdlc_rx_filt_chk (
    input logic clk,
    input logic rst_n,
    input logic transp_en,
    input logic cmd_rrst,
    input logic cmd_rack,
    input logic fifo_empty,
    input logic st_abort,
    input logic st_ovf,
    input logic st_crc_err,
    input logic irq_eom,
    input logic irq_ovf
);
    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_abort && !cmd_rrst) |=> st_abort); // R2
    AST_HALT_NO_EOM: assert property (@(posedge clk) disable iff (!rst_n)
        st_abort |-> !irq_eom); // R2
    AST_RRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rrst |=> (!st_abort && !st_ovf && !st_crc_err && fifo_empty && !irq_eom)); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovf && !cmd_rrst) |=> st_ovf); // R4
    AST_OVF_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> (st_ovf && !fifo_empty)); // R4
    AST_CRC_PLAIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!transp_en && !cmd_rrst) |=> (!irq_eom || !st_crc_err)); // R5
    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rack && !cmd_rrst) |=> (irq_eom || $stable(st_crc_err))); // R6
endmodule

bind hdlc_rx_filt hdlc_rx_filt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .transp_en(transp_en),
    .cmd_rrst(cmd_rrst), .cmd_rack(cmd_rack), .fifo_empty(fifo_empty),
    .st_abort(st_abort), .st_ovf(st_ovf), .st_crc_err(st_crc_err),
    .irq_eom(irq_eom), .irq_ovf(irq_ovf)
);

// File: tb/sim_hdlc_rx_filt.sv
module sim_hdlc_rx_filt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, bit_in = 1'b0, transp_en = 1'b0;
    logic [7:0] addr_val = '0, addr_mask = '0;
    logic       cmd_rrst = 1'b0, cmd_rack = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data, eom_count;
    logic       fifo_empty, st_abort, st_ovf, st_crc_err;
    logic       irq_ready, irq_eom, irq_ovf;

    always #2 clk = ~clk;

    hdlc_rx_filt u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .transp_en(transp_en), .addr_val(addr_val), .addr_mask(addr_mask),
        .cmd_rrst(cmd_rrst), .cmd_rack(cmd_rack), .rd_en(rd_en),
        .rd_data(rd_data), .fifo_empty(fifo_empty), .st_abort(st_abort),
        .st_ovf(st_ovf), .st_crc_err(st_crc_err), .eom_count(eom_count),
        .irq_ready(irq_ready), .irq_eom(irq_eom), .irq_ovf(irq_ovf)
    );

    int n_chk = 0, n_fail = 0;
    int eom_seen = 0, rdy_seen = 0, ovf_seen = 0;
    int ones_tx = 0, nsent = 0;
    logic [7:0] sent [64];

    always @(posedge clk) begin
        if (irq_eom)   eom_seen++;
        if (irq_ready) rdy_seen++;
        if (irq_ovf)   ovf_seen++;
    end

    // {transp[35], addr[34:27], mask[26:19], first[18:11], len[10:5], bad[4], acc[3], cerr[2], pad[1:0]}
    localparam logic [35:0] VEC [6] = '{
        {1'b1, 8'h35, 8'h00, 8'h35, 6'd4, 1'b0, 1'b1, 1'b0, 2'b00},  // R7 exact match
        {1'b1, 8'hA0, 8'h0F, 8'hA7, 6'd3, 1'b0, 1'b1, 1'b0, 2'b00},  // R7 low nibble masked
        {1'b1, 8'hA0, 8'h0E, 8'hA1, 6'd3, 1'b0, 1'b0, 1'b0, 2'b00},  // R7/R8 bit0 differs
        {1'b1, 8'h35, 8'hFF, 8'hC2, 6'd5, 1'b1, 1'b1, 1'b1, 2'b00},  // R5 bad FCS
        {1'b0, 8'h12, 8'h00, 8'h99, 6'd3, 1'b1, 1'b1, 1'b0, 2'b00},  // R5/R8 plain mode
        {1'b1, 8'h7E, 8'h00, 8'h7E, 6'd2, 1'b0, 1'b1, 1'b0, 2'b00}   // R1 flag-like byte
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_data_bit(input logic b);
        send_bit(b);
        ones_tx = b ? ones_tx + 1 : 0;
        if (ones_tx == 5) begin
            send_bit(1'b0);
            ones_tx = 0;
        end
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        ones_tx = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    function automatic logic [7:0] pay(input int k);
        if (k == 1) return 8'h7E;
        if (k == 2) return 8'hFF;
        return 8'(k * 19);
    endfunction

    function automatic logic [15:0] crc_ref(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++)
                c = (c[0] ^ sent[k][i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        return c;
    endfunction

    task automatic build(input logic [7:0] first, input int len, input bit bad);
        logic [15:0] fcs;
        sent[0] = first;
        for (int k = 1; k < len; k++) sent[k] = pay(k);
        fcs = ~crc_ref(len);
        if (bad) fcs[0] = ~fcs[0];
        sent[len]     = fcs[7:0];
        sent[len + 1] = fcs[15:8];
        nsent = len + 2;
    endtask

    task automatic send_frame();
        send_flag();
        for (int k = 0; k < nsent; k++) send_byte(sent[k]);
        send_flag();
        repeat (4) @(negedge clk);
    endtask

    task automatic read_chk(input int from, input int n, input string req);
        int bad_at = -1;
        logic [7:0] got = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (bad_at < 0 && rd_data !== sent[from + k]) begin
                bad_at = k;
                got = rd_data;
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        if (bad_at < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(got), int'(sent[from + bad_at]));
    endtask

    task automatic pulse_rack();
        @(negedge clk); cmd_rack = 1'b1;
        @(negedge clk); cmd_rack = 1'b0;
    endtask

    task automatic pulse_rrst();
        @(negedge clk); cmd_rrst = 1'b1;
        @(negedge clk); cmd_rrst = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int e0, r0, o0;
        logic [35:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_empty && !st_abort && !st_ovf && !st_crc_err, "R3 reset state",
            {fifo_empty, st_abort, st_ovf, st_crc_err}, 4'b1000);

        for (int r = 0; r < 6; r++) begin
            v = VEC[r];
            transp_en = v[35];
            addr_val  = v[34:27];
            addr_mask = v[26:19];
            build(v[18:11], int'(v[10:5]), v[4]);
            e0 = eom_seen;
            send_frame();
            if (v[3]) begin
                chk(eom_seen == e0 + 1, "R10 eom pulse", eom_seen - e0, 1);
                chk(eom_count == 8'(nsent), "R10 eom count", eom_count, nsent);
                chk(st_crc_err == v[2], "R5 crc result", st_crc_err, v[2]);
                read_chk(0, nsent, "R1 R7 stored bytes");
                chk(st_crc_err == v[2], "R6 crc held before ack", st_crc_err, v[2]);
                pulse_rack();
                @(negedge clk);
                chk(!st_crc_err, "R6 cleared by ack", st_crc_err, 0);
            end else begin
                chk(eom_seen == e0 && fifo_empty, "R8 mismatch dropped",
                    {eom_seen - e0, 1'b0, fifo_empty}, 1);
            end
            chk(fifo_empty, "R1 fifo drained", fifo_empty, 1);
        end

        // Abort and halt
        transp_en = 1'b1; addr_val = 8'h35; addr_mask = 8'h00;
        e0 = eom_seen;
        send_flag();
        send_byte(8'h35);
        send_byte(8'h11);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        ones_tx = 0;
        repeat (3) @(negedge clk);
        chk(st_abort && eom_seen == e0, "R2 abort status", st_abort, 1);
        build(8'h35, 3, 1'b0);
        send_frame();
        chk(st_abort && eom_seen == e0, "R2 halted until reset", eom_seen - e0, 0);
        pulse_rrst();
        @(negedge clk);
        chk(!st_abort && fifo_empty, "R3 rrst clears abort", {st_abort, fifo_empty}, 2'b01);
        send_frame();
        chk(eom_seen == e0 + 1, "R3 hunting after rrst", eom_seen - e0, 1);
        read_chk(0, nsent, "R1 bytes after rrst");

        // rrst clears crc error
        build(8'h35, 3, 1'b1);
        send_frame();
        chk(st_crc_err, "R5 bad frame flagged", st_crc_err, 1);
        pulse_rrst();
        @(negedge clk);
        chk(!st_crc_err && fifo_empty, "R3 rrst clears crc", st_crc_err, 0);

        // Overflow and ready threshold
        transp_en = 1'b0;
        build(8'h44, 34, 1'b0);
        r0 = rdy_seen; o0 = ovf_seen; e0 = eom_seen;
        send_frame();
        chk(rdy_seen == r0 + 1, "R9 ready pulse", rdy_seen - r0, 1);
        chk(ovf_seen == o0 + 4, "R4 overflow pulses", ovf_seen - o0, 4);
        chk(st_ovf, "R4 overflow status", st_ovf, 1);
        chk(eom_count == 8'd36, "R10 long count", eom_count, 36);
        read_chk(4, 32, "R4 oldest overwritten");
        chk(st_ovf && fifo_empty, "R4 overflow sticky", st_ovf, 1);
        pulse_rrst();
        @(negedge clk);
        chk(!st_ovf, "R3 rrst clears overflow", st_ovf, 0);

        finish_run();
    end
endmodule